// File: doc/BRIEF.md
# Receive Byte Buffer with Watermark Flow Control

This block holds bytes that arrive from a serial receiver until a consumer takes them. Storage is a 256-entry byte array addressed by two free-running 8-bit pointers: the write side owns one, the read side owns the other. The count of stored bytes is the pointer difference taken modulo 256. Because of that, one slot always stays unused and at most 255 bytes can be held.

A ready-to-send style output, `cts`, tells the far-end transmitter when it may send. It drops once a write brings the count to the stop level (240). It rises again only when a read brings the count below the resume level (224). The gap between the two levels gives the sender time to react to a stop request. It also keeps the line from toggling when the count hovers near one level.

The read side works in show-ahead fashion. The oldest byte is visible on `rd_data` whenever `rd_avail` is high, and a read request removes it. A write that arrives when the buffer is full is dropped and sets a sticky flag. Software-free recovery uses a synchronous clear input.

Top module: `rx_wmark_fifo`

## Requirements
- R1: After asynchronous reset (`rst_n` low) the count is 0, `rd_avail` is 0, `cts` is 1 (clear to send) and `ovf` is 0.
- R2: A write (`wr_vld` high at a clock edge) with a count below 255 stores `wr_data` and raises `occ` by one after that edge.
- R3: Bytes leave in arrival order. While `rd_avail` is 1, `rd_data` shows the oldest stored byte. A read request (`rd_req` high at a clock edge) removes that byte and lowers `occ` by one.
- R4: `occ` equals written minus read bytes modulo 256, and `rd_avail` is 1 exactly when `occ` is non-zero.
- R5: A read request while `occ` is 0 has no effect: `occ` stays 0 and `rd_avail` stays 0.
- R6: When a write leaves the count at 240 or more, `cts` is 0 (stop) after that edge. A write leaving 239 or less does not lower it.
- R7: When a read leaves the count below 224, `cts` returns to 1 after that edge. A read that leaves 224 or more keeps `cts` at 0.
- R8: A write arriving while `occ` is 255 is dropped: the count and the stored bytes are unchanged, and `ovf` becomes 1 and stays 1.
- R9: `ovf_clr` high at a clock edge clears `ovf`. If a dropped write occurs in the same cycle, `ovf` is set instead.
- R10: A read and a write in the same cycle, with a count between 1 and 254, are both performed: `occ` and `cts` are unchanged and the written byte enters behind the rest.
- R11: Both pointers wrap past 255 without disturbing order or count, so streams far longer than 256 bytes pass through intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_vld | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| rd_req | input | 1 | Read request from the consumer |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| rd_avail | output | 1 | At least one byte is stored |
| occ | output | 8 | Number of stored bytes |
| cts | output | 1 | 1 = sender may transmit, 0 = stop |
| ovf | output | 1 | Sticky: a write was dropped on full |
| ovf_clr | input | 1 | Synchronous clear of `ovf` |

## Verification
The bench builds the block with its defaults: 8-bit data and pointers, a stop level of 240 and a resume level of 224. These are small enough that directed filling reaches the full count of 255, both thresholds and the dropped-write case in a few hundred cycles. Thousands of random cycles then wrap the pointers many times over. The random phases alternate between write-heavy and read-heavy bias, so the count sweeps repeatedly through the hysteresis band between 224 and 240 from both directions.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

   // Line state toward the far-end transmitter.
   typedef enum logic {
      LINK_STOP = 1'b0,
      LINK_GO   = 1'b1
   } link_e;

   // Entries addressed by a pointer of the given width.
   function automatic int entries_for(input int ptr_w);
      return 1 << ptr_w;
   endfunction

endpackage

// File: rtl/rwf_ptr.sv
module rwf_ptr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] ptr
);

   logic [AW-1:0] ptr_q;

   // Free-running; wraps by natural overflow.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
   parameter int DW          = 8,
   parameter int AW          = 8,
   parameter bit STORE_FLOPS = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = rwf_pkg::entries_for(AW);

   generate
      if (STORE_FLOPS == 1'b0) begin : g_array
         // Plain array, asynchronous read port.
         logic [DW-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we) begin
               mem[waddr] <= wdata;
            end
         end

         assign rdata = mem[raddr];
      end else begin : g_regs
         // One register per entry with its own decoded enable.
         logic [DEPTH-1:0][DW-1:0] cells;

         for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            logic [DW-1:0] q;

            always_ff @(posedge clk) begin
               if (we && (waddr == AW'(i))) begin
                  q <= wdata;
               end
            end

            assign cells[i] = q;
         end

         assign rdata = cells[raddr];
      end
   endgenerate

endmodule

// File: rtl/rwf_flow.sv
module rwf_flow
   import rwf_pkg::*;
#(
   parameter int AW       = 8,
   parameter int STOP_LVL = 240,
   parameter int GO_LVL   = 224
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_acc,
   input  logic          rd_acc,
   input  logic [AW-1:0] occ_nxt,
   output logic          cts
);

   localparam logic [AW-1:0] STOP_C = AW'(STOP_LVL);
   localparam logic [AW-1:0] GO_C   = AW'(GO_LVL);

   link_e st_q;
   link_e st_d;

   // Decisions use the count as it will be after this edge.
   always_comb begin
      st_d = st_q;
      if (wr_acc && (occ_nxt >= STOP_C)) begin
         st_d = LINK_STOP;
      end else if (rd_acc && (occ_nxt < GO_C)) begin
         st_d = LINK_GO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LINK_GO;
      end else begin
         st_q <= st_d;
      end
   end

   assign cts = (st_q == LINK_GO);

endmodule

// File: rtl/rx_wmark_fifo.sv
module rx_wmark_fifo
   import rwf_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 8,
   parameter int STOP_LVL    = 240,
   parameter int GO_LVL      = 224,
   parameter bit STORE_FLOPS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_vld,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic [DW-1:0] rd_data,
   output logic          rd_avail,
   output logic [AW-1:0] occ,
   output logic          cts,
   output logic          ovf,
   input  logic          ovf_clr
);

   localparam int            DEPTH  = entries_for(AW);
   localparam logic [AW-1:0] FULL_C = AW'(DEPTH - 1);

   // Elaboration-time parameter checks.
   generate
      if (DW < 1) begin : g_bad_dw
         $error("rx_wmark_fifo: DW must be at least 1");
      end
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("rx_wmark_fifo: AW must lie in 2..12");
      end
      if (GO_LVL < 1 || GO_LVL >= STOP_LVL) begin : g_bad_go
         $error("rx_wmark_fifo: GO_LVL must be positive and below STOP_LVL");
      end
      if (STOP_LVL > DEPTH - 1) begin : g_bad_stop
         $error("rx_wmark_fifo: STOP_LVL must not exceed DEPTH-1");
      end
   endgenerate

   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] occ_now;
   logic [AW-1:0] occ_nxt;
   logic          wr_acc;
   logic          rd_acc;
   logic          ovf_q;

   assign occ_now = wr_ptr - rd_ptr;
   assign wr_acc  = wr_vld && (occ_now != FULL_C);
   assign rd_acc  = rd_req && (occ_now != '0);

   always_comb begin
      unique case ({wr_acc, rd_acc})
         2'b10:   occ_nxt = occ_now + 1'b1;
         2'b01:   occ_nxt = occ_now - 1'b1;
         default: occ_nxt = occ_now;
      endcase
   end

   rwf_ptr #(.AW(AW)) u_wr_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wr_acc),
      .ptr   (wr_ptr)
   );

   rwf_ptr #(.AW(AW)) u_rd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rd_acc),
      .ptr   (rd_ptr)
   );

   rwf_store #(
      .DW          (DW),
      .AW          (AW),
      .STORE_FLOPS (STORE_FLOPS)
   ) u_store (
      .clk   (clk),
      .we    (wr_acc),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (rd_data)
   );

   rwf_flow #(
      .AW       (AW),
      .STOP_LVL (STOP_LVL),
      .GO_LVL   (GO_LVL)
   ) u_flow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_acc  (wr_acc),
      .rd_acc  (rd_acc),
      .occ_nxt (occ_nxt),
      .cts     (cts)
   );

   // Sticky drop flag; a new drop outranks the clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wr_vld && !wr_acc) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end

   assign ovf      = ovf_q;
   assign occ      = occ_now;
   assign rd_avail = (occ_now != '0);

endmodule

// File: rtl/rwf_chk.sv
module rwf_chk #(
   parameter int AW       = 8,
   parameter int STOP_LVL = 240,
   parameter int GO_LVL   = 224
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_vld,
   input logic          rd_req,
   input logic          rd_avail,
   input logic [AW-1:0] occ,
   input logic          cts,
   input logic          ovf,
   input logic          ovf_clr
);

   localparam logic [AW-1:0] FULL_C  = AW'((1 << AW) - 1);
   localparam logic [AW-1:0] STOP_M1 = AW'(STOP_LVL - 1);
   localparam logic [AW-1:0] GO_C    = AW'(GO_LVL);

   // R2: lone accepted write raises the count by one
   a_r2_write_count: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && !rd_req && occ != FULL_C) |=> (occ == AW'($past(occ) + 1'b1)));

   // R5: read on empty leaves the buffer empty
   a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_avail && !wr_vld) |=> (occ == '0 && !rd_avail));

   // R6: write reaching the stop level requests stop
   a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && !rd_req && occ >= STOP_M1 && occ != FULL_C) |=> !cts);

   // R7: read dropping below the resume level releases the sender
   a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_avail && !wr_vld && occ <= GO_C) |=> cts);

   // R7: read that stays at or above the resume level keeps stop
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cts && rd_req && rd_avail && !wr_vld && occ > GO_C) |=> !cts);

   // R8: write while full is dropped and flagged
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && !rd_req && occ == FULL_C) |=> (ovf && occ == FULL_C));

   // R9: clear without a drop empties the flag
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !(wr_vld && occ == FULL_C)) |=> !ovf);

   // R10: simultaneous read and write keep count and line state
   a_r10_both: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && rd_req && rd_avail && occ != FULL_C) |=> ($stable(occ) && $stable(cts)));

   // R4: availability tracks a non-zero count
   a_r4_avail: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_avail == (occ != '0)));

endmodule

bind rx_wmark_fifo rwf_chk #(
   .AW       (AW),
   .STOP_LVL (STOP_LVL),
   .GO_LVL   (GO_LVL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_vld   (wr_vld),
   .rd_req   (rd_req),
   .rd_avail (rd_avail),
   .occ      (occ),
   .cts      (cts),
   .ovf      (ovf),
   .ovf_clr  (ovf_clr)
);

// File: tb/rx_wmark_fifo_tb.sv
module rx_wmark_fifo_tb;

   localparam int STOP_LVL = 240;
   localparam int GO_LVL   = 224;
   localparam int FULL     = 255;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_vld = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_req = 1'b0;
   logic [7:0] rd_data;
   logic       rd_avail;
   logic [7:0] occ;
   logic       cts;
   logic       ovf;
   logic       ovf_clr = 1'b0;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // Bench model state
   byte unsigned mq[$];
   bit           m_stop = 1'b0;
   bit           m_ovf  = 1'b0;

   always #2 clk = ~clk;

   rx_wmark_fifo u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_vld   (wr_vld),
      .wr_data  (wr_data),
      .rd_req   (rd_req),
      .rd_data  (rd_data),
      .rd_avail (rd_avail),
      .occ      (occ),
      .cts      (cts),
      .ovf      (ovf),
      .ovf_clr  (ovf_clr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected next state from the requirements.
   function automatic void model_step(input bit wv, input byte unsigned wd,
                                      input bit rr, input bit cl);
      int  n;
      bit  wacc;
      bit  racc;
      n    = mq.size();
      wacc = wv && (n != FULL);
      racc = rr && (n != 0);
      if (wv && !wacc)   m_ovf = 1'b1;
      else if (cl)       m_ovf = 1'b0;
      if (racc) void'(mq.pop_front());
      if (wacc) mq.push_back(wd);
      n = mq.size();
      if (wacc && n >= STOP_LVL)   m_stop = 1'b1;
      else if (racc && n < GO_LVL) m_stop = 1'b0;
   endfunction

   task automatic compare_all(input string tag);
      chk({tag, " occ"},   int'(occ),      mq.size());
      chk({tag, " avail"}, int'(rd_avail), int'(mq.size() != 0));
      chk({tag, " cts"},   int'(cts),      int'(!m_stop));
      chk({tag, " ovf"},   int'(ovf),      int'(m_ovf));
      if (mq.size() != 0) chk({tag, " data"}, int'(rd_data), int'(mq[0]));
   endtask

   task automatic cyc(input bit wv, input byte unsigned wd, input bit rr,
                      input bit cl, input string tag);
      @(negedge clk);
      wr_vld  = wv;
      wr_data = wd;
      rd_req  = rr;
      ovf_clr = cl;
      model_step(wv, wd, rr, cl);
      @(posedge clk);
      #1;
      compare_all(tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      // R1 reset state
      compare_all("R1 reset");

      // R5: reads on empty
      cyc(0, 8'h00, 1, 0, "R5 empty read");
      cyc(0, 8'h00, 1, 0, "R5 empty read again");

      // R2/R6: fill to just below the stop level, then cross it
      for (int i = 0; i < STOP_LVL - 1; i++) cyc(1, 8'(i ^ 8'h5A), 0, 0, "R2 fill");
      chk("R6 cts high at 239", int'(cts), 1);
      cyc(1, 8'hC3, 0, 0, "R6 reach stop level");
      chk("R6 cts low at 240", int'(cts), 0);

      // R10 in the stopped region
      cyc(1, 8'h11, 1, 0, "R10 both while stopped");

      // Fill to full, then drop
      while (mq.size() < FULL) cyc(1, 8'(mq.size() * 3), 0, 0, "R4 fill to full");
      chk("R4 occ full", int'(occ), 255);
      cyc(1, 8'hEE, 0, 0, "R8 dropped write");
      chk("R8 flag set", int'(ovf), 1);
      cyc(0, 8'h00, 0, 0, "R8 flag sticky");

      // R9: clear, then set and clear together
      cyc(0, 8'h00, 0, 1, "R9 clear");
      chk("R9 cleared", int'(ovf), 0);
      cyc(1, 8'hEF, 0, 1, "R9 drop beats clear");
      chk("R9 set wins", int'(ovf), 1);
      cyc(0, 8'h00, 0, 1, "R9 clear again");

      // R3/R7/R8: drain past the resume level, checking order
      while (mq.size() > GO_LVL) cyc(0, 8'h00, 1, 0, "R8 contents kept R3 order");
      chk("R7 stays stopped at 224", int'(cts), 0);
      cyc(0, 8'h00, 1, 0, "R7 drop below resume");
      chk("R7 resumed at 223", int'(cts), 1);
      while (mq.size() > 0) cyc(0, 8'h00, 1, 0, "R3 drain");
      chk("R4 empty after drain", int'(rd_avail), 0);

      // R10 at low fill
      cyc(1, 8'hA1, 0, 0, "R10 prime");
      cyc(1, 8'hA2, 1, 0, "R10 both low");
      cyc(0, 8'h00, 1, 0, "R10 order after both");

      // R11: random traffic with alternating bias, many pointer wraps
      for (int ph = 0; ph < 16; ph++) begin
         int wp;
         wp = (ph % 2 == 0) ? 75 : 30;
         for (int k = 0; k < 500; k++) begin
            bit wv, rr, cl;
            wv = ($urandom % 100) < wp;
            rr = ($urandom % 100) < (105 - wp);
            cl = ($urandom % 50) == 0;
            cyc(wv, 8'($urandom), rr, cl, "R11 random");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule